// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Datapath

This block holds a small bank of wide accumulators and performs a signed fractional multiply and one accumulator update in the same clock cycle. Each issued operation multiplies two signed operands in Q1.15 form. The result is the doubled product, so it is a Q1.31 value. That product may then be added to the chosen accumulator, subtracted from it, or loaded into it. All of this completes at a single clock edge, with no pipeline stage between the multiplier and the adder.

Each accumulator is as wide as a full product plus a set of guard bits. With the defaults this is 32 + 8 = 40 bits. When saturation is enabled for an operation, both the product and the updated accumulator are clamped to the signed product range. When saturation is disabled, the result wraps in the full accumulator width. A flag then reports that the guard bits no longer sign-extend the product-width value.

A condition input can cancel the accumulator and flag update of an operation. The product register still updates when the condition is low. A DSP sequencer uses this to run conditional accumulate steps without branching.

Top module: `satmac_dp`

## Requirements
- R1: After reset, every accumulator, the product output and all four flags read zero.
- R2: On each cycle with `valid_i` high, `prod_o` becomes 2·a·b, sign-extended to the accumulator width. This holds whatever the values of `opcode_i` and `cond_i`.
- R3: If both operands are the most negative value, the product saturates to the largest positive product-width value (0x007FFFFFFF by default) when `sat_en_i` is high. When `sat_en_i` is low, the product equals +2^31 (0x0080000000) instead. A written saturated product sets the saturation flag.
- R4: Opcode 2'b01 (add) writes accumulator[sel] + product into the selected accumulator, using the product of that same cycle.
- R5: Opcode 2'b10 (subtract) writes accumulator[sel] − product into the selected accumulator.
- R6: Opcode 2'b11 (load) writes the product of that cycle into the selected accumulator.
- R7: Opcode 2'b00, or `valid_i` low, leaves every accumulator and every flag unchanged.
- R8: With `cond_i` low, no accumulator and no flag changes, for any opcode.
- R9: With `sat_en_i` high, a result outside the signed product-width range is clamped to 0x007FFFFFFF or 0xFF80000000, and `sat_o` is set.
- R10: With `sat_en_i` low, a result wraps in the accumulator width. `ovf_o` is set exactly when the guard bits of the written value differ from copies of the product-width sign bit.
- R11: `neg_o` and `zero_o` report the sign of the last written accumulator value and whether that value is zero.
- R12: A write changes only the accumulator selected by `acc_sel_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issues an operation this cycle |
| opcode_i | input | 2 | 00 none, 01 add, 10 subtract, 11 load |
| acc_sel_i | input | 1 | Accumulator chosen for the update |
| op_a_i | input | 16 | Signed fractional operand A |
| op_b_i | input | 16 | Signed fractional operand B |
| sat_en_i | input | 1 | Saturate this operation's product and result |
| cond_i | input | 1 | Update accumulator and flags only when high |
| prod_o | output | 40 | Registered product |
| acc_o | output | 80 | All accumulators, accumulator 0 in the low bits |
| ovf_o | output | 1 | Guard bits of last written value are not a sign extension |
| sat_o | output | 1 | Last write was clamped |
| neg_o | output | 1 | Last written value is negative |
| zero_o | output | 1 | Last written value is zero |

## Verification
The bench builds the block with 5-bit operands and 3 guard bits. Products are then 10 bits wide and accumulators 13 bits wide. At that size the bench sweeps all 1024 operand pairs, including the most-negative-squared case, and runs a shifting mix of opcodes, condition values, saturation modes and accumulator selects. Narrow accumulators saturate and wrap after a few accumulate steps, so the clamp, wrap and overflow-flag paths are all reached many times. The expected values come from plain integer arithmetic.

// File: rtl/satmac_pkg.sv
package satmac_pkg;

    typedef enum logic [1:0] {
        ALU_NOP  = 2'b00,
        ALU_ADD  = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_LOAD = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sat;
        logic neg;
        logic zero;
    } mac_flags_t;

endpackage

// File: rtl/frac_mult.sv
module frac_mult #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8
) (
    input  logic [OP_W-1:0]              op_a,
    input  logic [OP_W-1:0]              op_b,
    input  logic                         sat_en,
    output logic [2*OP_W+GUARD_W-1:0]    prod,
    output logic                         clamped
);
    localparam int VAL_W = 2 * OP_W;
    localparam int ACC_W = VAL_W + GUARD_W;

    logic [VAL_W-1:0] a_ext, b_ext, raw;
    logic [VAL_W:0]   dbl;
    logic             over;

    always_comb begin
        a_ext   = {{OP_W{op_a[OP_W-1]}}, op_a};
        b_ext   = {{OP_W{op_b[OP_W-1]}}, op_b};
        raw     = a_ext * b_ext;
        dbl     = {raw, 1'b0};
        // only (-max) * (-max) reaches +2^(VAL_W-1)
        over    = dbl[VAL_W] ^ dbl[VAL_W-1];
        clamped = sat_en & over;
        if (clamped)
            prod = {{(GUARD_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
        else
            prod = {{(GUARD_W-1){dbl[VAL_W]}}, dbl};
    end

    // R3
    mult_clamp_chk: assert final (!(clamped && (op_a[OP_W-2:0] != '0 || op_b[OP_W-2:0] != '0)));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import satmac_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] prod,
    input  alu_op_e          op,
    input  logic             sat_en,
    input  logic             prod_clamped,
    output logic [ACC_W-1:0] res,
    output mac_flags_t       flags
);
    localparam int GUARD_W = ACC_W - VAL_W;
    localparam logic [ACC_W-1:0] MAXV = {{(GUARD_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {{(GUARD_W+1){1'b1}}, {(VAL_W-1){1'b0}}};

    logic [ACC_W:0] ea, ep, ex;
    logic           in_rng, clamp;

    always_comb begin
        ea = {acc_in[ACC_W-1], acc_in};
        ep = {prod[ACC_W-1], prod};
        case (op)
            ALU_ADD: ex = ea + ep;
            ALU_SUB: ex = ea - ep;
            default: ex = ep;
        endcase
        in_rng = (&ex[ACC_W:VAL_W-1]) | ~(|ex[ACC_W:VAL_W-1]);
        clamp  = sat_en & ~in_rng;
        if (clamp)
            res = ex[ACC_W] ? MINV : MAXV;
        else
            res = ex[ACC_W-1:0];
        flags.ovf  = ~((&res[ACC_W-1:VAL_W-1]) | ~(|res[ACC_W-1:VAL_W-1]));
        flags.sat  = clamp | prod_clamped;
        flags.neg  = res[ACC_W-1];
        flags.zero = ~(|res);
    end

endmodule

// File: rtl/acc_bank.sv
module acc_bank
    import satmac_pkg::*;
#(
    parameter int NUM_ACC = 2,
    parameter int ACC_W   = 40,
    parameter int SEL_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [ACC_W-1:0]         wdata,
    input  mac_flags_t               wflags,
    output logic [NUM_ACC*ACC_W-1:0] acc_flat,
    output mac_flags_t               flags
);
    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        mac_flags_t                    flg;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < NUM_ACC; i++) begin
                if (SEL_W'(i) == sel) st_d.acc[i] = wdata;
            end
            st_d.flg = wflags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < NUM_ACC; g++) begin : g_out
            assign acc_flat[g*ACC_W +: ACC_W] = st_q.acc[g];

            // R12 and R7/R8: an accumulator moves only when written and selected
            acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && sel == SEL_W'(g)) |=> st_q.acc[g] == $past(st_q.acc[g]));
        end
    endgenerate

    assign flags = st_q.flg;

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> st_q.flg == $past(st_q.flg));

endmodule

// File: rtl/satmac_dp.sv
module satmac_dp
    import satmac_pkg::*;
#(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8,
    parameter int NUM_ACC = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       valid_i,
    input  logic [1:0]                                 opcode_i,
    input  logic [(NUM_ACC>1 ? $clog2(NUM_ACC) : 1)-1:0] acc_sel_i,
    input  logic [OP_W-1:0]                            op_a_i,
    input  logic [OP_W-1:0]                            op_b_i,
    input  logic                                       sat_en_i,
    input  logic                                       cond_i,
    output logic [2*OP_W+GUARD_W-1:0]                  prod_o,
    output logic [NUM_ACC*(2*OP_W+GUARD_W)-1:0]        acc_o,
    output logic                                       ovf_o,
    output logic                                       sat_o,
    output logic                                       neg_o,
    output logic                                       zero_o
);
    localparam int VAL_W = 2 * OP_W;
    localparam int ACC_W = VAL_W + GUARD_W;
    localparam int SEL_W = NUM_ACC > 1 ? $clog2(NUM_ACC) : 1;

    typedef struct packed {
        logic [ACC_W-1:0] prod;
    } prod_t;

    prod_t            pr_d, pr_q;
    logic [ACC_W-1:0] prod_now, acc_cur, alu_res;
    logic             prod_clamped, wr_en;
    alu_op_e          op;
    mac_flags_t       alu_flags, flags_q;

    assign op = alu_op_e'(opcode_i);

    frac_mult #(.OP_W(OP_W), .GUARD_W(GUARD_W)) u_mult (
        .op_a    (op_a_i),
        .op_b    (op_b_i),
        .sat_en  (sat_en_i),
        .prod    (prod_now),
        .clamped (prod_clamped)
    );

    always_comb begin
        acc_cur = acc_o[int'(acc_sel_i)*ACC_W +: ACC_W];
    end

    acc_alu #(.VAL_W(VAL_W), .ACC_W(ACC_W)) u_alu (
        .acc_in       (acc_cur),
        .prod         (prod_now),
        .op           (op),
        .sat_en       (sat_en_i),
        .prod_clamped (prod_clamped),
        .res          (alu_res),
        .flags        (alu_flags)
    );

    always_comb begin
        wr_en = valid_i & cond_i & (op != ALU_NOP);
        pr_d  = pr_q;
        if (valid_i) pr_d.prod = prod_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .sel      (acc_sel_i),
        .wdata    (alu_res),
        .wflags   (alu_flags),
        .acc_flat (acc_o),
        .flags    (flags_q)
    );

    assign prod_o = pr_q.prod;
    assign ovf_o  = flags_q.ovf;
    assign sat_o  = flags_q.sat;
    assign neg_o  = flags_q.neg;
    assign zero_o = flags_q.zero;

    // R9
    sat_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sat_en_i) |=> !ovf_o);

    // R3
    prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && sat_en_i) |=>
            ((&prod_o[ACC_W-1:VAL_W-1]) || !(|prod_o[ACC_W-1:VAL_W-1])));

    // R11
    neg_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> neg_o == acc_o[int'($past(acc_sel_i))*ACC_W + ACC_W - 1]);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && sat_o));

    // R2
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(prod_o));

endmodule

// File: tb/tb_satmac_dp.sv
module tb_satmac_dp;
    localparam int OP_W    = 5;
    localparam int GUARD_W = 3;
    localparam int NUM_ACC = 2;
    localparam int VAL_W   = 2 * OP_W;
    localparam int ACC_W   = VAL_W + GUARD_W;
    localparam longint MAXV = (longint'(1) <<< (VAL_W - 1)) - 1;
    localparam longint MINV = -(longint'(1) <<< (VAL_W - 1));

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       valid_i = 1'b0;
    logic [1:0]                 opcode_i = 2'b00;
    logic [0:0]                 acc_sel_i = 1'b0;
    logic [OP_W-1:0]            op_a_i = '0;
    logic [OP_W-1:0]            op_b_i = '0;
    logic                       sat_en_i = 1'b0;
    logic                       cond_i = 1'b0;
    logic [ACC_W-1:0]           prod_o;
    logic [NUM_ACC*ACC_W-1:0]   acc_o;
    logic                       ovf_o, sat_o, neg_o, zero_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    longint m_acc [NUM_ACC];
    longint m_prod;
    bit     m_ovf, m_sat, m_neg, m_zero;

    satmac_dp #(.OP_W(OP_W), .GUARD_W(GUARD_W), .NUM_ACC(NUM_ACC)) dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .acc_sel_i(acc_sel_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .sat_en_i(sat_en_i), .cond_i(cond_i), .prod_o(prod_o), .acc_o(acc_o),
        .ovf_o(ovf_o), .sat_o(sat_o), .neg_o(neg_o), .zero_o(zero_o)
    );

    always #5 clk = ~clk;

    function automatic longint wrap_acc(longint v);
        logic [ACC_W-1:0] t;
        t = v[ACC_W-1:0];
        return longint'($signed(t));
    endfunction

    function automatic longint acc_port(int i);
        logic [ACC_W-1:0] t;
        t = acc_o[i*ACC_W +: ACC_W];
        return longint'($signed(t));
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check("R2", "product", wrap_acc(longint'(prod_o)), m_prod);
        for (int i = 0; i < NUM_ACC; i++)
            check(req, $sformatf("acc%0d", i), acc_port(i), m_acc[i]);
        check(req, "ovf", longint'(ovf_o), longint'(m_ovf));
        check(req, "sat", longint'(sat_o), longint'(m_sat));
        check("R11", "neg", longint'(neg_o), longint'(m_neg));
        check("R11", "zero", longint'(zero_o), longint'(m_zero));
    endtask

    // one operation; model updated from the requirements, compared after the edge
    task automatic step(int a, int b, int op, int sel, bit sat, bit cond, bit vld,
                        string req);
        longint p, r;
        bit pc, cl;
        valid_i   = vld;
        opcode_i  = op[1:0];
        acc_sel_i = sel[0:0];
        op_a_i    = a[OP_W-1:0];
        op_b_i    = b[OP_W-1:0];
        sat_en_i  = sat;
        cond_i    = cond;
        @(posedge clk);
        @(negedge clk);
        p  = 2 * longint'(a) * longint'(b);
        pc = sat && (p > MAXV);
        if (pc) p = MAXV;
        if (vld) m_prod = p;
        if (vld && cond && op != 0) begin
            if (op == 1)      r = m_acc[sel] + p;
            else if (op == 2) r = m_acc[sel] - p;
            else              r = p;
            cl = 1'b0;
            if (sat) begin
                if (r > MAXV) begin r = MAXV; cl = 1'b1; end
                if (r < MINV) begin r = MINV; cl = 1'b1; end
            end else begin
                r = wrap_acc(r);
            end
            m_acc[sel] = r;
            m_ovf  = (r > MAXV) || (r < MINV);
            m_sat  = cl || pc;
            m_neg  = r < 0;
            m_zero = r == 0;
        end
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_ACC; i++) m_acc[i] = 0;
        m_prod = 0;
        {m_ovf, m_sat, m_neg, m_zero} = 4'b0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 most-negative squared, with and without saturation
        step(-16, -16, 3, 0, 1'b1, 1'b1, 1'b1, "R3");
        step(-16, -16, 3, 1, 1'b0, 1'b1, 1'b1, "R3");
        // R6 load, R4 add, R5 subtract
        step(7, -3, 3, 0, 1'b0, 1'b1, 1'b1, "R6");
        step(5, 6, 1, 0, 1'b0, 1'b1, 1'b1, "R4");
        step(-9, 4, 2, 0, 1'b0, 1'b1, 1'b1, "R5");
        // R8 condition low blocks write, product still updates
        step(15, 15, 1, 0, 1'b1, 1'b0, 1'b1, "R8");
        // R7 no-op and idle cycle
        step(11, -7, 0, 1, 1'b0, 1'b1, 1'b1, "R7");
        step(3, 3, 1, 1, 1'b0, 1'b1, 1'b0, "R7");
        // R11 zero result
        step(0, 9, 3, 1, 1'b0, 1'b1, 1'b1, "R11");
        // R9 clamp upward then downward
        for (int k = 0; k < 4; k++) step(15, 15, 1, 0, 1'b1, 1'b1, 1'b1, "R9");
        for (int k = 0; k < 8; k++) step(15, 15, 2, 0, 1'b1, 1'b1, 1'b1, "R9");
        // R10 wrap without saturation
        for (int k = 0; k < 12; k++) step(-16, 15, 1, 1, 1'b0, 1'b1, 1'b1, "R10");

        // sweep every operand pair, varying opcode, select, mode and condition
        for (int a = -16; a < 16; a++) begin
            for (int b = -16; b < 16; b++) begin
                int  op, sel;
                bit  sat, cond;
                string req;
                op   = (a + b + 32) % 4;
                sel  = ((a + 16) >> 1) % 2 ^ ((b + 16) % 2);
                sat  = (((a + 16) >> 2) % 2) == 1;
                cond = ((a * 7 + b + 200) % 5) != 0;
                if (!cond)        req = "R8";
                else if (op == 0) req = "R7";
                else if (sat)     req = "R9";
                else              req = "R10";
                if (op == 1 && cond) req = {req, "/R4/R12"};
                if (op == 2 && cond) req = {req, "/R5/R12"};
                if (op == 3 && cond) req = {req, "/R6/R12"};
                step(a, b, op, sel, sat, cond, 1'b1, req);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule